// File: doc/BRIEF.md
# Indexed Codec Control Register Port

This block is the host-facing control port of an audio codec. A byte-wide host bus with chip select, read and write strobes and a 2-bit address reaches four direct ports. Through an index pointer, one of them opens a bank of sixteen indexed control registers. The block keeps the pointer and a mode-change-enable flag that guards the clock/format and interface-configuration registers. It also keeps a sticky interrupt flag and one programmed-I/O address that carries playback data on writes and capture data on reads.

Converter-side logic feeds the block captured samples, per-sample overrange flags, interrupt events and an initialisation-busy level. The block exports every indexed register as a flat vector, the interrupt level, the playback byte with a strobe, and a playback sample into which capture data is optionally mixed digitally. Host strobes are one-clock pulses synchronous to `clk`. Reads are combinational while chip select and the read strobe are both high.

Top module: `codec_regport`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads these values: mode-change-enable = 1, index = 0, interrupt flag = 0, indexed register 8 = 0x0C, register 9 = 0x08, and every other indexed register = 0x00.
- R2: A write to address 0 loads the index from data bits 3:0 and mode-change-enable from bit 6. A read of address 0 returns {`init_busy` at bit 7, mode-change-enable at bit 6, zeros at bits 5:4, index at bits 3:0}.
- R3: A write to address 1 updates the indexed register selected by the current index on the next clock edge. A read of address 1 returns that register.
- R4: While mode-change-enable is 0, writes to indexed registers 8 and 9 are ignored. While it is 1, they are accepted.
- R5: Reserved bits read as 0 and ignore writes. These are bit 7 of register 8, bit 1 of register 13, and all of register 15.
- R6: Register 11 holds overrange flags: bit 0 for the left channel and bit 1 for the right. They load from `ovr_in` on every `smp_valid` clock. Bits 7:2 read 0, and host writes to register 11 have no effect.
- R7: Bit 0 of the status port (address 2) is a sticky interrupt flag, and bits 7:1 read 0. `irq_set` sets the flag. Any host write to address 2 clears it. If both happen in the same clock, the set wins. `irq` equals the flag.
- R8: A write to address 3 loads `play_data`, and `play_stb` is high for exactly the following clock. A read of address 3 returns the capture byte, which loads from `cap_data` on each `cap_valid` clock.
- R9: When bit 0 of register 13 is 1, `mix_out` is the signed sum of `play_data` and the capture byte, saturated to 0x7F or 0x80. When that bit is 0, `mix_out` equals `play_data`. Capture reads are unchanged either way.
- R10: `host_oe` is high exactly when `host_cs` and `host_rd` are both high. While `host_oe` is low, `host_rdata` is 0.
- R11: `cfg_regs[8*i+7:8*i]` presents indexed register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Chip select |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe (one-clock pulse) |
| host_addr | input | 2 | Direct port select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_oe | output | 1 | Read data bus enable |
| init_busy | input | 1 | Initialisation in progress, shown in index port bit 7 |
| irq_set | input | 1 | Interrupt event from converter side |
| cap_valid | input | 1 | Capture byte strobe |
| cap_data | input | 8 | Capture byte |
| smp_valid | input | 1 | Sample strobe for overrange update |
| ovr_in | input | 2 | Overrange flags {right, left} |
| irq | output | 1 | Interrupt level |
| mce | output | 1 | Mode-change-enable flag |
| play_data | output | 8 | Playback byte |
| play_stb | output | 1 | Playback byte updated |
| mix_out | output | 8 | Playback sample after optional digital mix |
| cfg_regs | output | 128 | All indexed registers, register i at bits 8i+7:8i |

## Verification
The bench builds the block with its default widths: an 8-bit data path and a 4-bit index. This places all sixteen indexed registers within reach, including the guarded pair, the hardware-owned overrange register and the fully reserved register 15. Random traffic toggles mode-change-enable often, so guarded writes land in both the locked and unlocked states. Converter-side strobes arrive randomly in the same clocks as status clears and index writes. Directed cases drive signed overflow in both directions through the mixer and collide a status clear with an interrupt event.

// File: rtl/codec_regport_pkg.sv
// Package: shared widths, register indices and per-register constants for
// the indexed codec control port. Assumes an 8-bit host data path.
package codec_regport_pkg;

    localparam int DATA_W    = 8;
    localparam int IDX_W     = 4;
    localparam int NREG      = 1 << IDX_W;
    localparam int ADDR_W    = 2;
    localparam int OVR_W     = 2;

    localparam int FMT_IDX   = 8;
    localparam int IFC_IDX   = 9;
    localparam int OVR_IDX   = 11;
    localparam int MIX_IDX   = 13;
    localparam int SPARE_IDX = 15;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [ADDR_W-1:0] {
        PORT_INDEX  = 2'd0,
        PORT_IDATA  = 2'd1,
        PORT_STATUS = 2'd2,
        PORT_PIO    = 2'd3
    } port_e;

    // Value loaded into indexed register i by reset.
    function automatic byte_t reg_reset_value(int unsigned i);
        case (i)
            FMT_IDX: return 8'h0C;
            IFC_IDX: return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    // Bits of indexed register i that the host may change.
    function automatic byte_t reg_host_mask(int unsigned i);
        case (i)
            FMT_IDX:   return 8'h7F;
            OVR_IDX:   return 8'h00;
            MIX_IDX:   return 8'hFD;
            SPARE_IDX: return 8'h00;
            default:   return 8'hFF;
        endcase
    endfunction

    // Registers writable only while mode-change-enable is set.
    function automatic bit reg_guarded(int unsigned i);
        return (i == FMT_IDX) || (i == IFC_IDX);
    endfunction

endpackage

// File: rtl/codec_host_decode.sv
// Host strobe decode: turns chip select, strobes and the direct address into
// one write pulse per direct port and a read enable. Assumes the write
// strobe is a one-clock pulse synchronous to the block clock.
module codec_host_decode
    import codec_regport_pkg::*;
(
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_index,
    output logic              wr_idata,
    output logic              wr_status,
    output logic              wr_pio,
    output logic              rd_en
);

    logic wr_any;

    // Per-port write pulse decode.
    always_comb begin
        wr_any    = cs && wr;
        wr_index  = wr_any && (port_e'(addr) == PORT_INDEX);
        wr_idata  = wr_any && (port_e'(addr) == PORT_IDATA);
        wr_status = wr_any && (port_e'(addr) == PORT_STATUS);
        wr_pio    = wr_any && (port_e'(addr) == PORT_PIO);
        rd_en     = cs && rd;
    end

endmodule

// File: rtl/codec_index_bank.sv
// Index pointer, mode-change-enable flag and the indexed register bank.
// Guarded registers ignore writes while the flag is clear; reserved bits
// stay zero; the overrange register is owned by the converter side.
module codec_index_bank
    import codec_regport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_index,
    input  logic               wr_idata,
    input  byte_t              wdata,
    input  logic               smp_valid,
    input  logic [OVR_W-1:0]   ovr_in,
    output logic [IDX_W-1:0]   idx,
    output logic               mce,
    output byte_t              sel_data,
    output logic [NREG*DATA_W-1:0] regs_flat
);

    localparam int MCE_BIT = 6;

    // Index pointer and mode-change-enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            mce <= 1'b1;
        end else if (wr_index) begin
            idx <= wdata[IDX_W-1:0];
            mce <= wdata[MCE_BIT];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam byte_t RST_V = reg_reset_value(g);
        localparam byte_t HMASK = reg_host_mask(g);
        byte_t q;

        if (g == OVR_IDX) begin : g_ovr
            // Overrange flags refreshed once per sample.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= RST_V;
                else if (smp_valid)
                    q <= {{(DATA_W-OVR_W){1'b0}}, ovr_in};
            end
        end else begin : g_host
            logic hit;
            // Host write decode with mode-change guard.
            always_comb begin
                hit = wr_idata && (idx == IDX_W'(g));
                if (reg_guarded(g) && !mce)
                    hit = 1'b0;
            end
            // Masked host update of this register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= RST_V;
                else if (hit)
                    q <= (q & ~HMASK) | (wdata & HMASK);
            end
        end

        assign regs_flat[g*DATA_W +: DATA_W] = q;
    end

    // Register selected by the index pointer.
    always_comb begin
        sel_data = regs_flat[idx*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/codec_mix_sat.sv
// Signed saturating adder for the digital mix of capture data into the
// playback sample. Assumes two's-complement samples of equal width.
module codec_mix_sat
    import codec_regport_pkg::*;
(
    input  byte_t en,
    input  byte_t play,
    input  byte_t cap,
    output byte_t mixed
);

    logic signed [DATA_W:0] sum;
    byte_t                  sat;

    // Widened sum and clamp on signed overflow.
    always_comb begin
        sum = $signed({play[DATA_W-1], play}) + $signed({cap[DATA_W-1], cap});
        if (sum[DATA_W] != sum[DATA_W-1])
            sat = sum[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
        else
            sat = sum[DATA_W-1:0];
        mixed = en[0] ? sat : play;
    end

endmodule

// File: rtl/codec_stream_port.sv
// Sticky interrupt flag, playback byte with update strobe and capture byte.
// Assumes an interrupt event and a status clear in one clock resolve to set.
module codec_stream_port
    import codec_regport_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_status,
    input  logic  wr_pio,
    input  byte_t wdata,
    input  logic  irq_set,
    input  logic  cap_valid,
    input  byte_t cap_data,
    output logic  irq_flag,
    output byte_t play_q,
    output logic  play_stb,
    output byte_t cap_q
);

    // Sticky interrupt flag: event sets, status write clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_flag <= 1'b0;
        else if (irq_set)
            irq_flag <= 1'b1;
        else if (wr_status)
            irq_flag <= 1'b0;
    end

    // Playback byte and its one-clock update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_q   <= '0;
            play_stb <= 1'b0;
        end else begin
            play_stb <= wr_pio;
            if (wr_pio)
                play_q <= wdata;
        end
    end

    // Capture byte from the converter side.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (cap_valid)
            cap_q <= cap_data;
    end

endmodule

// File: rtl/codec_regport.sv
// Top of the indexed codec control port: host decode, index bank, stream
// port and digital mixer, plus the direct-port read multiplexer.
module codec_regport
    import codec_regport_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_cs,
    input  logic                    host_rd,
    input  logic                    host_wr,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic [DATA_W-1:0]       host_rdata,
    output logic                    host_oe,
    input  logic                    init_busy,
    input  logic                    irq_set,
    input  logic                    cap_valid,
    input  logic [DATA_W-1:0]       cap_data,
    input  logic                    smp_valid,
    input  logic [OVR_W-1:0]        ovr_in,
    output logic                    irq,
    output logic                    mce,
    output logic [DATA_W-1:0]       play_data,
    output logic                    play_stb,
    output logic [DATA_W-1:0]       mix_out,
    output logic [NREG*DATA_W-1:0]  cfg_regs
);

    logic             wr_index, wr_idata, wr_status, wr_pio, rd_en;
    logic [IDX_W-1:0] idx;
    byte_t            sel_data, cap_q, mux_data;
    logic             irq_flag;

    codec_host_decode u_dec (
        .cs        (host_cs),
        .rd        (host_rd),
        .wr        (host_wr),
        .addr      (host_addr),
        .wr_index  (wr_index),
        .wr_idata  (wr_idata),
        .wr_status (wr_status),
        .wr_pio    (wr_pio),
        .rd_en     (rd_en)
    );

    codec_index_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_index  (wr_index),
        .wr_idata  (wr_idata),
        .wdata     (host_wdata),
        .smp_valid (smp_valid),
        .ovr_in    (ovr_in),
        .idx       (idx),
        .mce       (mce),
        .sel_data  (sel_data),
        .regs_flat (cfg_regs)
    );

    codec_stream_port u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_status (wr_status),
        .wr_pio    (wr_pio),
        .wdata     (host_wdata),
        .irq_set   (irq_set),
        .cap_valid (cap_valid),
        .cap_data  (cap_data),
        .irq_flag  (irq_flag),
        .play_q    (play_data),
        .play_stb  (play_stb),
        .cap_q     (cap_q)
    );

    codec_mix_sat u_mix (
        .en    (cfg_regs[MIX_IDX*DATA_W +: DATA_W]),
        .play  (play_data),
        .cap   (cap_q),
        .mixed (mix_out)
    );

    // Direct-port read multiplexer.
    always_comb begin
        case (port_e'(host_addr))
            PORT_INDEX:  mux_data = {init_busy, mce, {(DATA_W-2-IDX_W){1'b0}}, idx};
            PORT_IDATA:  mux_data = sel_data;
            PORT_STATUS: mux_data = {{(DATA_W-1){1'b0}}, irq_flag};
            default:     mux_data = cap_q;
        endcase
    end

    // Bus drive only during a selected read.
    always_comb begin
        host_oe    = rd_en;
        host_rdata = rd_en ? mux_data : '0;
        irq        = irq_flag;
    end

endmodule

// File: rtl/codec_regport_chk.sv
// Checker for codec_regport, attached by bind. Observes ports and the
// index pointer only.
module codec_regport_chk
    import codec_regport_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_cs,
    input  logic                    host_wr,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [DATA_W-1:0]       host_wdata,
    input  logic [DATA_W-1:0]       host_rdata,
    input  logic                    host_oe,
    input  logic                    irq_set,
    input  logic                    smp_valid,
    input  logic                    irq,
    input  logic                    mce,
    input  logic [DATA_W-1:0]       play_data,
    input  logic                    play_stb,
    input  logic [NREG*DATA_W-1:0]  cfg_regs,
    input  logic [IDX_W-1:0]        idx
);

    logic wr_st, wr_id;
    assign wr_st = host_cs && host_wr && (host_addr == 2'd2);
    assign wr_id = host_cs && host_wr && (host_addr == 2'd1);

    // R10
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_oe |-> (host_rdata == '0));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_st) |=> irq);

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && !irq_set) |=> !irq);

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq);

    // R4
    fmt_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_id && !mce && idx == IDX_W'(FMT_IDX)) |=> $stable(cfg_regs[FMT_IDX*DATA_W +: DATA_W]));

    // R4
    ifc_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_id && !mce && idx == IDX_W'(IFC_IDX)) |=> $stable(cfg_regs[IFC_IDX*DATA_W +: DATA_W]));

    // R6
    ovr_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid) |=> $stable(cfg_regs[OVR_IDX*DATA_W +: DATA_W]));

    // R8
    play_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_wr && host_addr == 2'd3) |=> (play_stb && play_data == $past(host_wdata)));

    // R5
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cfg_regs[SPARE_IDX*DATA_W +: DATA_W] == '0));

endmodule

bind codec_regport codec_regport_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs    (host_cs),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .host_oe    (host_oe),
    .irq_set    (irq_set),
    .smp_valid  (smp_valid),
    .irq        (irq),
    .mce        (mce),
    .play_data  (play_data),
    .play_stb   (play_stb),
    .cfg_regs   (cfg_regs),
    .idx        (idx)
);

// File: tb/codec_regport_tb.sv
module codec_regport_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_cs = 0, host_rd = 0, host_wr = 0;
    logic [1:0]   host_addr = 0;
    logic [7:0]   host_wdata = 0;
    logic [7:0]   host_rdata;
    logic         host_oe;
    logic         init_busy = 0, irq_set = 0, cap_valid = 0, smp_valid = 0;
    logic [7:0]   cap_data = 0;
    logic [1:0]   ovr_in = 0;
    logic         irq, mce, play_stb;
    logic [7:0]   play_data, mix_out;
    logic [127:0] cfg_regs;

    int errors = 0;
    int checks = 0;

    logic [7:0] m_reg [16];
    logic [3:0] m_idx;
    logic       m_mce, m_irq, m_stb;
    logic [7:0] m_play, m_cap;

    always #5 clk = ~clk;

    codec_regport u_dut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_oe(host_oe), .init_busy(init_busy),
        .irq_set(irq_set), .cap_valid(cap_valid), .cap_data(cap_data),
        .smp_valid(smp_valid), .ovr_in(ovr_in), .irq(irq), .mce(mce),
        .play_data(play_data), .play_stb(play_stb), .mix_out(mix_out),
        .cfg_regs(cfg_regs)
    );

    function automatic logic [7:0] rst_val(int i);
        return (i == 8) ? 8'h0C : (i == 9) ? 8'h08 : 8'h00;
    endfunction

    function automatic logic [7:0] wmask(int i);
        case (i)
            8:  return 8'h7F;
            11: return 8'h00;
            13: return 8'hFD;
            15: return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] sat_add(logic [7:0] a, logic [7:0] b);
        int s;
        s = $signed(a) + $signed(b);
        if (s > 127) return 8'h7F;
        if (s < -128) return 8'h80;
        return s[7:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = rst_val(i);
        m_idx = 0; m_mce = 1; m_irq = 0; m_stb = 0; m_play = 0; m_cap = 0;
    endtask

    // One bus clock: drive at negedge, check outputs, update model at posedge.
    task automatic step(logic cs, logic rd, logic wr, logic [1:0] a, logic [7:0] wd,
                        logic ib, logic iset, logic cv, logic [7:0] cd,
                        logic sv, logic [1:0] ov);
        logic [7:0] exp_rd;
        @(negedge clk);
        host_cs = cs; host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
        init_busy = ib; irq_set = iset; cap_valid = cv; cap_data = cd;
        smp_valid = sv; ovr_in = ov;
        #1;
        // R7 / R8 / R9 / R11 registered outputs
        check("R7 irq", irq, m_irq);
        check("R2 mce", mce, m_mce);
        check("R8 play_data", play_data, m_play);
        check("R8 play_stb", play_stb, m_stb);
        check("R9 mix_out", mix_out, m_reg[13][0] ? sat_add(m_play, m_cap) : m_play);
        for (int i = 0; i < 16; i++)
            check($sformatf("R11 cfg_regs[%0d]", i), cfg_regs[i*8 +: 8], m_reg[i]);
        // R10 bus enable and read data
        check("R10 host_oe", host_oe, cs && rd);
        case (a)
            2'd0: exp_rd = {ib, m_mce, 2'b00, m_idx};
            2'd1: exp_rd = m_reg[m_idx];
            2'd2: exp_rd = {7'd0, m_irq};
            default: exp_rd = m_cap;
        endcase
        if (cs && rd) check($sformatf("R3 read addr %0d", a), host_rdata, exp_rd);
        else          check("R10 quiet bus", host_rdata, 8'h00);
        @(posedge clk);
        m_stb = cs && wr && (a == 2'd3);
        if (cs && wr) begin
            case (a)
                2'd0: begin m_idx = wd[3:0]; m_mce = wd[6]; end
                2'd1: if (!((m_idx == 8 || m_idx == 9) && !m_mce))
                          m_reg[m_idx] = (m_reg[m_idx] & ~wmask(m_idx)) | (wd & wmask(m_idx));
                2'd2: m_irq = 1'b0;
                default: m_play = wd;
            endcase
        end
        if (iset) m_irq = 1'b1;
        if (cv) m_cap = cd;
        if (sv) m_reg[11] = {6'd0, ov};
    endtask

    task automatic wr_reg(logic [1:0] a, logic [7:0] d);
        step(1, 0, 1, a, d, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rd_reg(logic [1:0] a);
        step(1, 1, 0, a, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state, index port readback (R2)
        rd_reg(2'd0);
        step(1, 1, 0, 2'd0, 0, 1, 0, 0, 0, 0, 0);   // R2 init_busy in bit 7
        rd_reg(2'd2);

        // R4 guarded registers locked with mce clear
        wr_reg(2'd0, 8'h08);                       // idx 8, mce 0
        wr_reg(2'd1, 8'h55);
        rd_reg(2'd1);
        wr_reg(2'd0, 8'h09);
        wr_reg(2'd1, 8'hAA);
        rd_reg(2'd1);
        wr_reg(2'd0, 8'h48);                       // idx 8, mce 1
        wr_reg(2'd1, 8'hFF);                       // R5 bit 7 stays zero
        rd_reg(2'd1);
        // R5 spare register
        wr_reg(2'd0, 8'h4F);
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1);
        // R6 overrange: host write ignored, sample loads
        wr_reg(2'd0, 8'h0B);
        wr_reg(2'd1, 8'hFF);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b10);
        rd_reg(2'd1);
        // R7 set and clear in the same clock: set wins
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        step(1, 0, 1, 2'd2, 8'h00, 0, 1, 0, 0, 0, 0);
        rd_reg(2'd2);
        wr_reg(2'd2, 8'h00);
        rd_reg(2'd2);
        // R8 / R9 mix saturation both ways
        wr_reg(2'd0, 8'h0D);
        wr_reg(2'd1, 8'h01);
        step(1, 0, 1, 2'd3, 8'h70, 0, 0, 1, 8'h70, 0, 0);
        rd_reg(2'd3);
        step(1, 0, 1, 2'd3, 8'h90, 0, 0, 1, 8'h90, 0, 0);
        rd_reg(2'd3);
        wr_reg(2'd1, 8'h00);
        rd_reg(2'd3);

        // Constrained random traffic
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [7:0] d;
            op = $urandom % 8;
            d  = 8'($urandom);
            if (($urandom % 3) == 0) d[3:0] = (($urandom % 2) != 0) ? 4'd8 : 4'd13;
            step(op < 7, op >= 4 && op < 7, op < 4, 2'($urandom), d,
                 1'($urandom), ($urandom % 8) == 0, ($urandom % 4) == 0, 8'($urandom),
                 ($urandom % 4) == 0, 2'($urandom));
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule